// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point numbers over several clock cycles. A word holds a sign bit in bit 31, a biased exponent in bits 30:23 (bias 127) and a fraction in bits 22:0. A normal number carries an implied leading one. An exponent field of zero marks a denormal, read as 0.fraction times 2^-126, with no implied one. An all-ones exponent marks infinity when the fraction is zero and NaN when it is not.

The caller presents both operands and a subtract select, then pulses `start` for one cycle. The block first unpacks the fields and then aligns the smaller-magnitude operand to the larger exponent. It adds or subtracts the significands, normalizes the sum and rounds it to nearest, with ties going to even. When rounding carries out of the significand, it goes back through normalization. It then presents the packed result with a one-cycle `done` pulse and three exception flags.

Top module: `fpa_seq_adder`

## Requirements
- R1: For finite operands, `result` is the sum (or difference when `subtract`=1) correctly rounded to single precision, with the larger operand's exponent kept and the sum renormalized so that a normal result has its leading one in the implied position.
- R2: Alignment keeps guard, round and sticky information, and rounding is to nearest with ties to even: half an ulp rounds toward the even fraction, and anything above half rounds up.
- R3: `subtract`=1 inverts the sign of `opb`. An exact zero produced by opposite-signed effective subtraction is +0 (0x00000000).
- R4: An operand whose exponent field is 0 is used as 0.fraction x 2^-126. A nonzero result too small to be normal is encoded with exponent field 0 and raises `exc_underflow`. A sum that reaches the normal range (e.g. 0x00800000) does not.
- R5: If rounding carries out of the 24-bit significand, the result is renormalized and the exponent is incremented (e.g. 0x3FFFFFFF + 0x33800000 = 0x40000000).
- R6: A result whose exponent would reach 255, before or after rounding, returns signed infinity (exponent field all ones, fraction 0) and raises `exc_overflow`.
- R7: Any NaN operand, or infinities of opposite effective sign, return 0x7FC00000 and raise `exc_invalid`.
- R8: An infinite operand with a finite or same-signed infinite partner returns that infinity with its effective sign and no flag.
- R9: Zero operands follow signed-zero rules: -0 + -0 = -0, +0 + -0 = +0, and zero plus x returns x with x's effective sign.
- R10: Operands and `subtract` are sampled only on a `start` in the idle state. A `start` while busy is ignored. `done` is high for exactly one cycle, and `result` and the flags stay unchanged until the next `done`.
- R11: While and after `rst`, `done`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| subtract | input | 1 | 1: opa - opb, 0: opa + opb |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed result, held between completions |
| exc_invalid | output | 1 | Invalid operation (NaN result) |
| exc_overflow | output | 1 | Result overflowed to infinity |
| exc_underflow | output | 1 | Nonzero result is denormal |

## Verification
The hardest path to reach from the ports runs from rounding back into normalization. Only a significand of all ones followed by a guard bit that forces an increment gets there. The stimulus builds those bit patterns on purpose. One case is an all-ones significand plus exactly half an ulp. Another is 1.0 minus 2^-25, where the borrow first shifts the sum left and rounding then carries back up to 1.0. A third is the largest finite value plus half its ulp, which reaches overflow only on the second pass through normalization.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W_DEF  = 8;
  localparam int FRAC_W_DEF = 23;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_NORM,
    ST_ROUND
  } fpa_state_t;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] word,
  output logic           sign,
  output logic [EW-1:0]  exp_eff,
  output logic [FW:0]    sig,
  output logic           is_inf,
  output logic           is_nan
);
  logic [EW-1:0] e_fld;
  logic [FW-1:0] f_fld;
  logic          e_zero;
  logic          e_full;

  assign sign    = word[EW+FW];
  assign e_fld   = word[EW+FW-1:FW];
  assign f_fld   = word[FW-1:0];
  assign e_zero  = (e_fld == '0);
  assign e_full  = &e_fld;
  // denormals: no hidden one, exponent treated as the minimum normal
  assign sig     = {~e_zero, f_fld};
  assign exp_eff = e_zero ? EW'(1) : e_fld;
  assign is_inf  = e_full & (f_fld == '0);
  assign is_nan  = e_full & (|f_fld);
endmodule

// File: rtl/fpa_rshift_sticky.sv
module fpa_rshift_sticky #(
  parameter int W   = 28,
  parameter int SHW = 8
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] shifted;
  logic [W-1:0] lost;
  logic [31:0]  amt32;

  assign amt32 = 32'(amt);

  always_comb begin
    shifted = '0;
    lost    = '0;
    dout    = '0;
    if (amt32 >= 32'(W)) begin
      dout[0] = |din;
    end else begin
      shifted = din >> amt;
      lost    = din & ~({W{1'b1}} << amt);
      dout    = shifted;
      dout[0] = shifted[0] | (|lost);
    end
  end
endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
  parameter int W  = 27,
  parameter int CW = 5
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpa_round.sv
module fpa_round #(
  parameter int W = 28
) (
  input  logic [W-2:0] din,
  output logic [W-1:0] dout
);
  logic inc;

  // bit 3 = lsb, bit 2 = guard, bit 1 = round, bit 0 = sticky
  assign inc  = din[2] & (din[1] | din[0] | din[3]);
  assign dout = {({1'b0, din[W-2:3]} + {{(W-4){1'b0}}, inc}), 3'b000};
endmodule

// File: rtl/fpa_seq_adder.sv
module fpa_seq_adder #(
  parameter int EXP_W  = fpa_pkg::EXP_W_DEF,
  parameter int FRAC_W = fpa_pkg::FRAC_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      subtract,
  input  logic [EXP_W+FRAC_W:0]     opa,
  input  logic [EXP_W+FRAC_W:0]     opb,
  output logic                      done,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      exc_invalid,
  output logic                      exc_overflow,
  output logic                      exc_underflow
);
  import fpa_pkg::*;

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int WORK_W = SIG_W + 4;
  localparam int EXPI_W = EXP_W + 2;
  localparam int LZ_W   = $clog2(WORK_W);
  localparam logic [EXP_W-1:0]  EXP_ONES = {EXP_W{1'b1}};
  localparam logic [EXPI_W-1:0] EXP_LIM  = EXPI_W'(EXP_ONES);
  localparam logic [WORD_W-1:0] QNAN     =
    {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  fpa_state_t          state_q;
  logic [WORD_W-1:0]   a_q, b_q;
  logic                sub_q;
  logic                sign_q, effsub_q;
  logic [EXPI_W-1:0]   exp_q;
  logic [WORK_W-1:0]   big_q, sml_q, acc_q;

  // ---------------- unpack ----------------
  logic               sa, sb_raw, sb;
  logic [EXP_W-1:0]   ea, eb;
  logic [SIG_W-1:0]   ma, mb;
  logic               inf_a, inf_b, nan_a, nan_b;

  fpa_unpack #(.EW(EXP_W), .FW(FRAC_W)) u_unp_a (
    .word(a_q), .sign(sa), .exp_eff(ea), .sig(ma), .is_inf(inf_a), .is_nan(nan_a));
  fpa_unpack #(.EW(EXP_W), .FW(FRAC_W)) u_unp_b (
    .word(b_q), .sign(sb_raw), .exp_eff(eb), .sig(mb), .is_inf(inf_b), .is_nan(nan_b));

  assign sb = sb_raw ^ sub_q;

  // ---------------- align ----------------
  logic               a_big;
  logic [EXP_W-1:0]   big_e, sml_e, diff;
  logic [SIG_W-1:0]   big_m, sml_m;
  logic               big_s;
  logic [WORK_W-1:0]  sml_aligned;

  assign a_big = {ea, ma} >= {eb, mb};
  assign big_e = a_big ? ea : eb;
  assign sml_e = a_big ? eb : ea;
  assign big_m = a_big ? ma : mb;
  assign sml_m = a_big ? mb : ma;
  assign big_s = a_big ? sa : sb;
  assign diff  = big_e - sml_e;

  fpa_rshift_sticky #(.W(WORK_W), .SHW(EXP_W)) u_align (
    .din({1'b0, sml_m, 3'b000}), .amt(diff), .dout(sml_aligned));

  // ---------------- add ----------------
  logic [WORK_W-1:0] sum;
  assign sum = effsub_q ? (big_q - sml_q) : (big_q + sml_q);

  // ---------------- normalize ----------------
  logic [LZ_W-1:0]   lz;
  logic [EXPI_W-1:0] room, lz_x, lsh;

  fpa_lzc #(.W(WORK_W-1), .CW(LZ_W)) u_lzc (.din(acc_q[WORK_W-2:0]), .cnt(lz));

  assign room = exp_q - EXPI_W'(1);
  assign lz_x = EXPI_W'(lz);
  assign lsh  = (lz_x > room) ? room : lz_x;

  // ---------------- round ----------------
  logic [WORK_W-1:0] rnd;
  fpa_round #(.W(WORK_W)) u_round (.din(acc_q[WORK_W-2:0]), .dout(rnd));

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      a_q           <= '0;
      b_q           <= '0;
      sub_q         <= 1'b0;
      sign_q        <= 1'b0;
      effsub_q      <= 1'b0;
      exp_q         <= '0;
      big_q         <= '0;
      sml_q         <= '0;
      acc_q         <= '0;
      done          <= 1'b0;
      result        <= '0;
      exc_invalid   <= 1'b0;
      exc_overflow  <= 1'b0;
      exc_underflow <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            a_q     <= opa;
            b_q     <= opb;
            sub_q   <= subtract;
            state_q <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          if (nan_a || nan_b || (inf_a && inf_b && (sa != sb))) begin
            result        <= QNAN;
            {exc_invalid, exc_overflow, exc_underflow} <= 3'b100;
            done          <= 1'b1;
            state_q       <= ST_IDLE;
          end else if (inf_a || inf_b) begin
            result        <= {(inf_a ? sa : sb), EXP_ONES, {FRAC_W{1'b0}}};
            {exc_invalid, exc_overflow, exc_underflow} <= 3'b000;
            done          <= 1'b1;
            state_q       <= ST_IDLE;
          end else begin
            big_q    <= {1'b0, big_m, 3'b000};
            sml_q    <= sml_aligned;
            exp_q    <= EXPI_W'(big_e);
            sign_q   <= big_s;
            effsub_q <= sa ^ sb;
            state_q  <= ST_ADD;
          end
        end
        ST_ADD: begin
          if (sum == '0) begin
            result        <= {sign_q & ~effsub_q, {(WORD_W-1){1'b0}}};
            {exc_invalid, exc_overflow, exc_underflow} <= 3'b000;
            done          <= 1'b1;
            state_q       <= ST_IDLE;
          end else begin
            acc_q   <= sum;
            state_q <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (acc_q[WORK_W-1]) begin
            acc_q <= {1'b0, acc_q[WORK_W-1:2], acc_q[1] | acc_q[0]};
            exp_q <= exp_q + EXPI_W'(1);
          end else begin
            acc_q <= acc_q << lsh;
            exp_q <= exp_q - lsh;
          end
          state_q <= ST_ROUND;
        end
        ST_ROUND: begin
          if (rnd[WORK_W-1]) begin
            acc_q   <= rnd;
            state_q <= ST_NORM;
          end else if (exp_q >= EXP_LIM) begin
            result        <= {sign_q, EXP_ONES, {FRAC_W{1'b0}}};
            {exc_invalid, exc_overflow, exc_underflow} <= 3'b010;
            done          <= 1'b1;
            state_q       <= ST_IDLE;
          end else begin
            result        <= {sign_q, (rnd[WORK_W-2] ? exp_q[EXP_W-1:0] : {EXP_W{1'b0}}),
                              rnd[WORK_W-3:3]};
            {exc_invalid, exc_overflow, exc_underflow} <= {2'b00, ~rnd[WORK_W-2]};
            done          <= 1'b1;
            state_q       <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_result_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result) && $stable(exc_invalid) && $stable(exc_overflow));

  p_nan_canon_r7: assert property (@(posedge clk) disable iff (rst)
    (done && exc_invalid) |-> (result == QNAN));

  p_ovf_inf_r6: assert property (@(posedge clk) disable iff (rst)
    (done && exc_overflow) |-> (result[WORD_W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}}));

  p_udf_tiny_r4: assert property (@(posedge clk) disable iff (rst)
    (done && exc_underflow) |->
      (result[WORD_W-2:FRAC_W] == '0) && (result[FRAC_W-1:0] != '0));

  p_norm_form_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ROUND) |->
      !acc_q[WORK_W-1] && (acc_q[WORK_W-2] || (exp_q == EXPI_W'(1))));
endmodule

// File: tb/fpa_seq_adder_bench.sv
module fpa_seq_adder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        subtract = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        done;
  logic [31:0] result;
  logic        exc_invalid, exc_overflow, exc_underflow;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  fpa_seq_adder u_fpa_seq_adder (
    .clk(clk), .rst(rst), .start(start), .subtract(subtract),
    .opa(opa), .opb(opb), .done(done), .result(result),
    .exc_invalid(exc_invalid), .exc_overflow(exc_overflow),
    .exc_underflow(exc_underflow));

  // {tag[3:0], sub, a, b, expected, flags{invalid,overflow,underflow}}
  localparam int NV = 29;
  localparam logic [103:0] VEC [NV] = '{
    {4'd1,  1'b0, 32'h3F800000, 32'h3F800000, 32'h40000000, 3'b000}, // R1 1+1
    {4'd1,  1'b0, 32'h3FC00000, 32'h40200000, 32'h40800000, 3'b000}, // R1 carry out
    {4'd1,  1'b1, 32'h3F800000, 32'h3F7FFFFF, 32'h33800000, 3'b000}, // R1 deep cancel
    {4'd3,  1'b1, 32'h40400000, 32'h3F800000, 32'h40000000, 3'b000}, // R3 3-1
    {4'd3,  1'b1, 32'h3F800000, 32'h40400000, 32'hC0000000, 3'b000}, // R3 1-3
    {4'd3,  1'b1, 32'h40A00000, 32'h40A00000, 32'h00000000, 3'b000}, // R3 x-x
    {4'd3,  1'b0, 32'hC0A00000, 32'h40A00000, 32'h00000000, 3'b000}, // R3 -x+x
    {4'd2,  1'b0, 32'h3F800000, 32'h33800000, 32'h3F800000, 3'b000}, // R2 tie even down
    {4'd2,  1'b0, 32'h3F800001, 32'h33800000, 32'h3F800002, 3'b000}, // R2 tie odd up
    {4'd2,  1'b0, 32'h3F800000, 32'h33C00000, 32'h3F800001, 3'b000}, // R2 above half
    {4'd2,  1'b0, 32'h3F800000, 32'h33800001, 32'h3F800001, 3'b000}, // R2 sticky
    {4'd2,  1'b0, 32'h3F800000, 32'h00000001, 32'h3F800000, 3'b000}, // R2 far shift
    {4'd5,  1'b1, 32'h3F800000, 32'h33000000, 32'h3F800000, 3'b000}, // R5 borrow then carry
    {4'd5,  1'b0, 32'h3FFFFFFF, 32'h33800000, 32'h40000000, 3'b000}, // R5 round carry
    {4'd6,  1'b0, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 3'b010}, // R6 +ovf
    {4'd6,  1'b0, 32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 3'b010}, // R6 -ovf
    {4'd6,  1'b0, 32'h7F7FFFFF, 32'h73000000, 32'h7F800000, 3'b010}, // R6 ovf via round
    {4'd4,  1'b0, 32'h00000001, 32'h00000001, 32'h00000002, 3'b001}, // R4 tiny sum
    {4'd4,  1'b0, 32'h00400000, 32'h00400000, 32'h00800000, 3'b000}, // R4 to normal
    {4'd4,  1'b1, 32'h00800000, 32'h00000001, 32'h007FFFFF, 3'b001}, // R4 to denormal
    {4'd7,  1'b0, 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 3'b100}, // R7 qnan in
    {4'd7,  1'b0, 32'h00000000, 32'h7F800001, 32'h7FC00000, 3'b100}, // R7 snan in
    {4'd7,  1'b1, 32'h7F800000, 32'h7F800000, 32'h7FC00000, 3'b100}, // R7 inf-inf
    {4'd8,  1'b0, 32'h7F800000, 32'h7F800000, 32'h7F800000, 3'b000}, // R8 inf+inf
    {4'd8,  1'b1, 32'h3F800000, 32'h7F800000, 32'hFF800000, 3'b000}, // R8 1-inf
    {4'd9,  1'b0, 32'h80000000, 32'h80000000, 32'h80000000, 3'b000}, // R9 -0+-0
    {4'd9,  1'b0, 32'h00000000, 32'h80000000, 32'h00000000, 3'b000}, // R9 +0+-0
    {4'd9,  1'b1, 32'h00000000, 32'h3F800000, 32'hBF800000, 3'b000}, // R9 0-1
    {4'd9,  1'b0, 32'h3F800000, 32'h80000000, 32'h3F800000, 3'b000}  // R9 1+-0
  };

  task automatic check(input bit cond, input string req,
                       input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic s, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] r, output logic [2:0] f, output bit ok);
    @(negedge clk);
    start = 1'b1; subtract = s; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    ok = 1'b0; r = '0; f = '0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin
        ok = 1'b1;
        r = result;
        f = {exc_invalid, exc_overflow, exc_underflow};
        break;
      end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [2:0]  f;
    bit          ok;
    logic [31:0] held;

    // R11: reset state
    repeat (3) @(negedge clk);
    check(!done && result == '0 && !exc_invalid && !exc_overflow && !exc_underflow,
          "R11 in reset", {done, result, 2'b00}, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && result == '0 && !exc_invalid && !exc_overflow && !exc_underflow,
          "R11 after reset", {done, result, 2'b00}, '0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      run_op(VEC[k][99], VEC[k][98:67], VEC[k][66:35], r, f, ok);
      check(ok && {r, f} == VEC[k][34:0], $sformatf("R%0d vector %0d", VEC[k][103:100], k),
            {r, f}, VEC[k][34:0]);
    end

    // R10: done is a single-cycle pulse
    run_op(1'b0, 32'h3F800000, 32'h40000000, r, f, ok);
    check(ok && r == 32'h40400000, "R10 op result", {r, f}, {32'h40400000, 3'b000});
    @(negedge clk);
    check(!done, "R10 pulse width", {34'd0, done}, '0);

    // R10: start while busy is ignored, result held afterwards
    @(negedge clk);
    start = 1'b1; subtract = 1'b0; opa = 32'h3F800000; opb = 32'h3F800000;
    @(negedge clk);
    opa = 32'h40400000; opb = 32'h40400000;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin ok = 1'b1; r = result; break; end
      @(negedge clk);
    end
    check(ok && r == 32'h40000000, "R10 busy start ignored", {r, 3'b000}, {32'h40000000, 3'b000});
    held = result;
    opa = 32'hC1200000; opb = 32'h7F800001; subtract = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!done && result == held, "R10 held without start",
            {done, result, 2'b00}, {1'b0, held, 2'b00});
    end

    // R11: reset clears a held result
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!done && result == '0, "R11 reset clears", {done, result, 2'b00}, '0);
    rst = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule